// File: doc/BRIEF.md
# PCI Bus Parking and Request Controller

This block sits on the initiator side of a PCI bridge port. It decides when the bridge may drive the address/data, command/byte-enable and parity lines on an idle bus to keep them at valid levels. It also raises the bridge's bus request and fires a one-clock strobe that starts a new transaction by asserting FRAME#. The block sees the bus grant, the bridge's internal wish to transfer, and the FRAME#/IRDY# lines, which tell it whether the bus is idle.

A static mode input selects how the block talks to the arbiter. In normal mode the request goes out on `req_n` and the grant comes in on `gnt_n`. In external-arbiter mode the pins are swapped over. The request leaves on `rmp_req_n`, a pin that is otherwise a grant output, and the grant arrives on `rmp_gnt_n`, a pin that is otherwise a request input. The unused pin of each pair is held inactive or ignored. The parking and start rules are the same in both modes.

Top module: `pci_park_ctrl`

## Requirements
- R1: While `rst_n` is low, `ad_cbe_oe`, `par_oe` and `start` are 0 and `req_n` and `rmp_req_n` are 1, whatever the other inputs are.
- R2: When a clock edge samples the active grant asserted (low), the bridge's request pin deasserted, and the bus idle (`frame_n` and `irdy_n` both 1), `ad_cbe_oe` is 1 after that edge.
- R3: `par_oe` rises exactly one clock after `ad_cbe_oe` while parking continues, and is never 1 while `ad_cbe_oe` is 0.
- R4: An edge that samples the active grant deasserted turns off both `ad_cbe_oe` and `par_oe` after that edge.
- R5: An edge that samples `frame_n` or `irdy_n` low (bus busy) turns off both enables, and no `start` pulse follows it.
- R6: A high `want_xfer` sampled at an edge, while no start is taken at that edge, drives the active request pin low after the edge. The request is released at the edge that takes the start.
- R7: If the block is parked (`ad_cbe_oe` is 1) and an edge samples `want_xfer` high with the grant still asserted and the bus idle, then `start` is 1 after that edge, and both enables are 0 in that same cycle.
- R8: If the request pin is asserted and an edge samples the grant asserted and the bus idle, then `start` pulses high after that edge. A `start` is only ever preceded by parking or by an asserted request.
- R9: `start` is a pulse that lasts one clock and is never high in two consecutive cycles.
- R10: When `ext_arb` is 1, the request appears on `rmp_req_n` and the grant is read from `rmp_gnt_n`. `req_n` stays 1 and `gnt_n` has no effect.
- R11: When `ext_arb` is 0, `rmp_req_n` stays 1 and `rmp_gnt_n` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_arb | input | 1 | 1 selects external-arbiter pin mapping |
| want_xfer | input | 1 | Internal wish to start a transaction, level |
| gnt_n | input | 1 | Bus grant in normal mode, active low |
| rmp_gnt_n | input | 1 | Remapped grant input in external-arbiter mode, active low |
| frame_n | input | 1 | Observed FRAME#, active low |
| irdy_n | input | 1 | Observed IRDY#, active low |
| req_n | output | 1 | Bus request in normal mode, active low |
| rmp_req_n | output | 1 | Remapped request output in external-arbiter mode, active low |
| ad_cbe_oe | output | 1 | Drive enable for AD and C/BE# lines |
| par_oe | output | 1 | Drive enable for PAR |
| start | output | 1 | One-clock strobe that asserts FRAME# for a new transaction |

## Verification
The state is four flops: the request, the two drive enables and the start strobe. A wrong value in any of them shows on a port one clock after the edge that sampled the inputs. A stale enable after grant loss or a busy bus shows at once on `ad_cbe_oe` or `par_oe`, as contention on the bus. A lost request shows as a request pin that stays high and a `start` that never comes. A doubled start shows as `start` high for two cycles. The bench therefore predicts every output for every cycle. It walks through parking, its stagger, grant loss, busy bus, the start from parking, the start from a request, and both pin mappings, and it compares one clock after each stimulus.

// File: rtl/pci_park_ctrl.sv
module pci_park_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_arb,
  input  logic want_xfer,
  input  logic gnt_n,
  input  logic rmp_gnt_n,
  input  logic frame_n,
  input  logic irdy_n,
  output logic req_n,
  output logic rmp_req_n,
  output logic ad_cbe_oe,
  output logic par_oe,
  output logic start
);

  logic req_q, ad_q, par_q, st_q;
  logic granted, idle, take, park_ok;

  assign granted = ext_arb ? ~rmp_gnt_n : ~gnt_n;
  assign idle    = frame_n & irdy_n;
  assign take    = want_xfer & granted & idle & ~st_q & (ad_q | req_q);
  assign park_ok = granted & ~req_q & idle & ~take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      ad_q  <= 1'b0;
      par_q <= 1'b0;
      st_q  <= 1'b0;
    end else begin
      req_q <= want_xfer & ~take;
      ad_q  <= park_ok;
      par_q <= park_ok & ad_q;
      st_q  <= take;
    end
  end

  assign req_n     = ext_arb ? 1'b1 : ~req_q;
  assign rmp_req_n = ext_arb ? ~req_q : 1'b1;
  assign ad_cbe_oe = ad_q;
  assign par_oe    = par_q;
  assign start     = st_q;

endmodule

// File: rtl/pci_park_ctrl_chk.sv
module pci_park_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ext_arb,
  input logic want_xfer,
  input logic gnt_n,
  input logic rmp_gnt_n,
  input logic frame_n,
  input logic irdy_n,
  input logic req_n,
  input logic rmp_req_n,
  input logic ad_cbe_oe,
  input logic par_oe,
  input logic start
);

  logic no_grant, busy;
  assign no_grant = ext_arb ? rmp_gnt_n : gnt_n;
  assign busy     = ~frame_n | ~irdy_n;

  assert_par_needs_ad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> ad_cbe_oe);

  assert_par_lags_ad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_oe) |-> $past(ad_cbe_oe));

  assert_grant_loss_tristate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    no_grant |=> (!ad_cbe_oe && !par_oe));

  assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!ad_cbe_oe && !start));

  assert_start_ends_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!ad_cbe_oe && !par_oe));

  assert_start_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> $past(ad_cbe_oe || !req_n || !rmp_req_n));

  assert_start_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

  assert_ext_req_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_arb |-> req_n);

  assert_norm_req_pin_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_arb |-> rmp_req_n);

  logic unused_ok;
  assign unused_ok = want_xfer;

endmodule

bind pci_park_ctrl pci_park_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ext_arb(ext_arb), .want_xfer(want_xfer),
  .gnt_n(gnt_n), .rmp_gnt_n(rmp_gnt_n), .frame_n(frame_n), .irdy_n(irdy_n),
  .req_n(req_n), .rmp_req_n(rmp_req_n), .ad_cbe_oe(ad_cbe_oe),
  .par_oe(par_oe), .start(start)
);

// File: tb/pci_park_ctrl_tb.sv
`timescale 1ns/1ps
module pci_park_ctrl_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_arb = 1'b0, want_xfer = 1'b0, gnt_n = 1'b1, rmp_gnt_n = 1'b1;
  logic frame_n = 1'b1, irdy_n = 1'b1;
  logic req_n, rmp_req_n, ad_cbe_oe, par_oe, start;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [4:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  pci_park_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_arb(ext_arb), .want_xfer(want_xfer),
    .gnt_n(gnt_n), .rmp_gnt_n(rmp_gnt_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .req_n(req_n), .rmp_req_n(rmp_req_n), .ad_cbe_oe(ad_cbe_oe),
    .par_oe(par_oe), .start(start)
  );

  // expected vector: {ad_cbe_oe, par_oe, start, req_n, rmp_req_n}
  task automatic step(input bit rst, input bit ext, input bit want,
                      input bit gn, input bit rgn, input bit fr, input bit ir,
                      input logic [4:0] e, input string tag);
    @(negedge clk);
    rst_n = ~rst; ext_arb = ext; want_xfer = want;
    gnt_n = gn; rmp_gnt_n = rgn; frame_n = fr; irdy_n = ir;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [4:0] e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {ad_cbe_oe, par_oe, start, req_n, rmp_req_n};
        checks++;
        if (a !== e) begin
          failures++;
          $display("FAIL %s actual=%b expected=%b", t, a, e);
        end
      end
    end
  end

  initial begin
    //   rst ext want gn rgn fr ir  expect
    step(1, 0, 0, 1, 1, 1, 1, 5'b00011, "R1 reset idle");
    step(1, 0, 1, 0, 1, 1, 1, 5'b00011, "R1 reset with grant and want");
    step(0, 0, 0, 0, 1, 1, 1, 5'b10011, "R2 park ad/cbe on");
    step(0, 0, 0, 0, 1, 1, 1, 5'b11011, "R3 par one clock later");
    step(0, 0, 0, 0, 1, 1, 1, 5'b11011, "R2 parking held");
    step(0, 0, 0, 1, 1, 1, 1, 5'b00011, "R4 grant loss tristate");
    step(0, 0, 0, 0, 1, 1, 1, 5'b10011, "R2 repark");
    step(0, 0, 0, 0, 1, 0, 1, 5'b00011, "R5 frame busy");
    step(0, 0, 0, 0, 1, 1, 1, 5'b10011, "R2 repark after frame");
    step(0, 0, 0, 0, 1, 1, 1, 5'b11011, "R3 par stagger again");
    step(0, 0, 0, 0, 1, 1, 0, 5'b00011, "R5 irdy busy");
    step(0, 0, 0, 0, 1, 1, 1, 5'b10011, "R2 repark after irdy");
    step(0, 0, 0, 0, 1, 1, 1, 5'b11011, "R3 full park");
    step(0, 0, 1, 0, 1, 1, 1, 5'b00111, "R7 start from parking");
    step(0, 0, 0, 0, 1, 0, 1, 5'b00011, "R9 start single pulse");
    step(0, 0, 0, 0, 1, 0, 0, 5'b00011, "R5 busy transaction");
    step(0, 0, 0, 0, 1, 1, 1, 5'b10011, "R2 park after transfer");
    step(0, 0, 0, 0, 1, 1, 1, 5'b11011, "R3 park after transfer");
    step(0, 0, 1, 1, 1, 1, 1, 5'b00001, "R6 request raised, R4 grant gone");
    step(0, 0, 1, 1, 1, 1, 1, 5'b00001, "R6 request held without grant");
    step(0, 0, 1, 0, 1, 0, 1, 5'b00001, "R5 no start while busy");
    step(0, 0, 1, 0, 1, 1, 1, 5'b00111, "R8 start after grant, R6 release");
    step(0, 0, 0, 0, 1, 0, 1, 5'b00011, "R9 start single pulse");
    step(0, 0, 0, 1, 1, 1, 1, 5'b00011, "R4 no grant no park");
    step(0, 0, 0, 1, 0, 1, 1, 5'b00011, "R11 remapped grant ignored");
    step(0, 0, 0, 1, 0, 1, 1, 5'b00011, "R11 remapped grant ignored again");
    step(1, 1, 0, 1, 1, 1, 1, 5'b00011, "R1 reset in ext mode");
    step(0, 1, 0, 0, 1, 1, 1, 5'b00011, "R10 normal grant ignored");
    step(0, 1, 0, 0, 1, 1, 1, 5'b00011, "R10 normal grant ignored again");
    step(0, 1, 0, 1, 0, 1, 1, 5'b10011, "R10 park on remapped grant");
    step(0, 1, 0, 1, 0, 1, 1, 5'b11011, "R3 ext par stagger");
    step(0, 1, 0, 1, 1, 1, 1, 5'b00011, "R4 ext grant loss");
    step(0, 1, 1, 1, 1, 1, 1, 5'b00010, "R10 request on remapped pin");
    step(0, 1, 1, 0, 1, 1, 1, 5'b00010, "R10 normal grant has no effect");
    step(0, 1, 1, 1, 0, 1, 1, 5'b00111, "R8 ext start one clock after grant");
    step(0, 1, 0, 1, 0, 0, 1, 5'b00011, "R9 ext start single pulse");
    step(0, 1, 0, 1, 0, 1, 1, 5'b10011, "R2 ext park idle");
    step(0, 1, 0, 1, 0, 1, 0, 5'b00011, "R5 ext busy drops park");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule